// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire debug link. It carries out one register access at a time. A request names the port group (access port or debug port), the direction, a 2-bit register address (address bits 3:2) and, for a write, a 32-bit word. The engine generates the link clock and shifts an 8-bit request header out on the data pin. It then releases the pin for a programmable number of turnaround clocks and reads a 3-bit acknowledge from the target. After that it either moves a 32-bit word plus parity in the proper direction or ends the access early.

The request side is a valid/ready stream. `req_ready` is high exactly when the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While the engine is busy, `req_ready` stays low, and the source must hold its request until it is taken. Fields presented while the engine is busy are not sampled. The result side has no back-pressure. `done` pulses for one cycle, and the acknowledge, read word and error flags then hold until the next request is taken. The data pin is split into `swdio_out`, `swdio_oe` and `swdio_in` for the pad cell.

Top module: `sw_dbg_host`

## Requirements
- R1: The header goes out least significant bit first. Bit0 = 1. Bit1 = `req_ap`. Bit2 = `req_read`. Bit3 = `req_addr[0]`. Bit4 = `req_addr[1]`. Bit5 makes bits 1 to 5 hold an even number of ones. Bit6 = 0. Bit7 = 1.
- R2: `swclk` is low whenever the engine is idle. Each bit lasts CLK_HALF cycles with `swclk` low followed by CLK_HALF cycles with it high. The host changes what it drives only as `swclk` falls, and it samples `swdio_in` as `swclk` rises.
- R3: Right after the header, and again right after the acknowledge, there are T bit times with `swdio_oe` = 0. T is `trn_len`, except that a value of 0 is treated as 1.
- R4: The acknowledge is three bits sampled first-to-last into `rsp_ack[0]`, `rsp_ack[1]` and `rsp_ack[2]`. The codes are OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100.
- R5: On a read with acknowledge OK, the engine samples 32 data bits (LSB first) and then one parity bit, followed by T undriven bits. `rsp_rdata` holds the word. `rsp_perr` = 1 when the 33 sampled bits hold an odd number of ones.
- R6: On a write with acknowledge OK, the second turnaround is followed by 32 driven data bits (LSB first) and then a parity bit that makes the 33 bits hold an even number of ones.
- R7: On an acknowledge of WAIT or FAULT there is no data phase. The access ends after the second turnaround, with `rsp_rdata` = 0 and `rsp_perr` = 0.
- R8: Any acknowledge other than the three codes sets `rsp_proto_err` = 1 and ends the access like R7. `rsp_proto_err` = 0 for the three codes.
- R9: `req_ready` = !`busy`. `busy` rises in the cycle after acceptance. `done` is a one-cycle pulse with `busy` low, and the results hold until the next acceptance.
- R10: While the engine is idle, `swdio_oe` = 0 and `swdio_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can take a request |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Word to write |
| trn_len | input | TRN_W | Turnaround length in bit times (0 acts as 1) |
| swclk | output | 1 | Generated link clock |
| swdio_out | output | 1 | Data pin value driven by the host |
| swdio_oe | output | 1 | Data pin output enable |
| swdio_in | input | 1 | Data pin value seen from the pad |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rsp_ack | output | 3 | Received acknowledge |
| rsp_rdata | output | 32 | Read word |
| rsp_perr | output | 1 | Read parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge is not a known code |

## Verification
Take a request accepted at edge N. Bit k of the access occupies the 2·CLK_HALF cycles after edge N + 2·CLK_HALF·k, and `swclk` is high in the second half of that span. `done` and the results appear exactly 2·CLK_HALF·n cycles after N, where n is the number of bits the access needs. The bench builds the expected bit list from the request and the acknowledge it plays back. It then compares `swclk`, the pin controls and `busy` on the falling system edge of every cycle of every bit. It checks the results in the cycle where `done` is due and again one cycle later. It drives each target bit for the whole bit time, so the single rising sample inside that bit falls on a stable value.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_HDR, PH_TRN1, PH_ACK, PH_RDAT, PH_TRN2, PH_WDAT
  } phase_e;

  localparam int HDR_BITS  = 8;
  localparam int ACK_BITS  = 3;
  localparam int WORD_W    = 32;
  localparam int DATA_BITS = WORD_W + 1;
  localparam int IXW       = $clog2(DATA_BITS);

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
endpackage

// File: rtl/sdh_hdr.sv
module sdh_hdr (
  input  logic       ap,
  input  logic       rd,
  input  logic [1:0] addr,
  output logic [7:0] hdr
);
  logic par;
  always_comb begin
    par = ap ^ rd ^ addr[0] ^ addr[1];
    hdr = {1'b1, 1'b0, par, addr[1], addr[0], rd, ap, 1'b1};
  end
endmodule

// File: rtl/sdh_clkgen.sv
module sdh_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sclk,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick    = run && (cnt_q == TOP);
  assign rise_ev = tick && !sclk;
  assign fall_ev = tick && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || start || !run) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (cnt_q == TOP) begin
      cnt_q <= '0;
      sclk  <= ~sclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_clk_parks_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> !sclk);
endmodule

// File: rtl/sdh_capture.sv
module sdh_capture
  import sdh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise_ev,
  input  phase_e            phase,
  input  logic [IXW-1:0]    bidx,
  input  logic              din,
  input  logic              finish,
  input  logic              fin_rd,
  output logic [2:0]        ack,
  output logic [WORD_W-1:0] rdata,
  output logic              perr,
  output logic              proto
);
  logic [2:0]           ack_q;
  logic [DATA_BITS-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ack_q <= '0;
      rd_q  <= '0;
      perr  <= 1'b0;
      proto <= 1'b0;
    end else begin
      if (rise_ev && phase == PH_ACK)  ack_q[bidx[1:0]] <= din;
      if (rise_ev && phase == PH_RDAT) rd_q[bidx]       <= din;
      if (finish) begin
        perr  <= fin_rd && (^rd_q);
        proto <= !(ack_q == ACK_OK || ack_q == ACK_WAIT || ack_q == ACK_FAULT);
      end
    end
  end

  assign ack   = ack_q;
  assign rdata = rd_q[WORD_W-1:0];

  assert_perr_needs_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    perr |-> (ack == ACK_OK));
  assert_proto_excludes_perr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto |-> !perr);
endmodule

// File: rtl/sw_dbg_host.sv
module sw_dbg_host
  import sdh_pkg::*;
#(
  parameter int CLK_HALF = 2,
  parameter int TRN_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ap,
  input  logic              req_read,
  input  logic [1:0]        req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [TRN_W-1:0]  trn_len,
  output logic              swclk,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              swdio_in,
  output logic              busy,
  output logic              done,
  output logic [2:0]        rsp_ack,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_perr,
  output logic              rsp_proto_err
);
  localparam int BW = (TRN_W > IXW) ? TRN_W : IXW;

  phase_e               phase_q, nxt;
  logic [BW-1:0]        bcnt_q, len;
  logic [7:0]           hdr_w, hdr_q;
  logic [DATA_BITS-1:0] wword_q;
  logic [TRN_W-1:0]     trn_q, trn_eff;
  logic                 busy_q, done_q, is_rd_q;
  logic                 accept, rise_ev, fall_ev, last, finish, ack_ok;

  assign accept  = req_valid && !busy_q;
  assign trn_eff = (trn_len == '0) ? TRN_W'(1) : trn_len;
  assign ack_ok  = (rsp_ack == ACK_OK);

  sdh_hdr u_hdr (.ap(req_ap), .rd(req_read), .addr(req_addr), .hdr(hdr_w));

  sdh_clkgen #(.HALF(CLK_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy_q),
    .sclk(swclk), .rise_ev(rise_ev), .fall_ev(fall_ev));

  always_comb begin
    case (phase_q)
      PH_HDR:           len = BW'(HDR_BITS - 1);
      PH_TRN1, PH_TRN2: len = BW'(trn_q) - 1'b1;
      PH_ACK:           len = BW'(ACK_BITS - 1);
      PH_RDAT, PH_WDAT: len = BW'(DATA_BITS - 1);
      default:          len = '0;
    endcase
    case (phase_q)
      PH_HDR:  nxt = PH_TRN1;
      PH_TRN1: nxt = PH_ACK;
      PH_ACK:  nxt = (ack_ok && is_rd_q) ? PH_RDAT : PH_TRN2;
      PH_RDAT: nxt = PH_TRN2;
      PH_TRN2: nxt = (ack_ok && !is_rd_q) ? PH_WDAT : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  assign last   = (bcnt_q == len);
  assign finish = fall_ev && last && (nxt == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= PH_IDLE;
      bcnt_q  <= '0;
      hdr_q   <= '0;
      wword_q <= '0;
      is_rd_q <= 1'b0;
      trn_q   <= TRN_W'(1);
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        phase_q <= PH_HDR;
        bcnt_q  <= '0;
        hdr_q   <= hdr_w;
        wword_q <= {^req_wdata, req_wdata};
        is_rd_q <= req_read;
        trn_q   <= trn_eff;
      end else if (fall_ev) begin
        if (last) begin
          bcnt_q  <= '0;
          phase_q <= nxt;
          if (nxt == PH_IDLE) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  sdh_capture u_cap (
    .clk(clk), .rst_n(rst_n), .clear(accept), .rise_ev(rise_ev),
    .phase(phase_q), .bidx(bcnt_q[IXW-1:0]), .din(swdio_in),
    .finish(finish), .fin_rd(is_rd_q && ack_ok),
    .ack(rsp_ack), .rdata(rsp_rdata), .perr(rsp_perr), .proto(rsp_proto_err));

  always_comb begin
    swdio_oe  = (phase_q == PH_HDR) || (phase_q == PH_WDAT);
    swdio_out = 1'b0;
    if (phase_q == PH_HDR)  swdio_out = hdr_q[bcnt_q[2:0]];
    if (phase_q == PH_WDAT) swdio_out = wword_q[bcnt_q[IXW-1:0]];
  end

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign done      = done_q;

  assert_accept_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !done));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_idle_clk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !swclk);
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!swdio_oe && !swdio_out));
  assert_drive_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));
  assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (swdio_oe && swdio_out && !swclk));
  assert_data_needs_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RDAT || phase_q == PH_WDAT) |-> (rsp_ack == ACK_OK));
endmodule

// File: tb/sw_dbg_host_tb.sv
module sw_dbg_host_tb;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ap = 1'b0, req_read = 1'b0;
  logic [1:0]  req_addr = '0, trn_len = '0;
  logic [31:0] req_wdata = '0;
  logic        swdio_in = 1'b0;
  logic        req_ready, swclk, swdio_out, swdio_oe, busy, done;
  logic        rsp_perr, rsp_proto_err;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  bit    e_oe [0:127];
  bit    e_out[0:127];
  bit    e_in [0:127];
  string e_tag[0:127];
  int    nb;

  always #5 clk = ~clk;

  sw_dbg_host #(.CLK_HALF(H), .TRN_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ap(req_ap), .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .trn_len(trn_len), .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
    .swdio_in(swdio_in), .busy(busy), .done(done), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .rsp_proto_err(rsp_proto_err));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit oe, input bit o, input bit i, input string tag);
    e_oe[nb] = oe; e_out[nb] = o; e_in[nb] = i; e_tag[nb] = tag; nb++;
  endtask

  task automatic run_txn(input bit ap, input bit rd, input logic [1:0] addr,
                         input logic [31:0] wd, input logic [2:0] ack,
                         input logic [31:0] rdv, input bit bad_par,
                         input logic [1:0] trn);
    int  t;
    bit  ok, par;
    bit  [7:0] hdr;
    logic [31:0] x_rdata;
    bit  x_perr, x_proto;
    t   = (trn == 0) ? 1 : int'(trn);
    nb  = 0;
    par = ap ^ rd ^ addr[0] ^ addr[1];
    hdr = {1'b1, 1'b0, par, addr[1], addr[0], rd, ap, 1'b1};
    for (int i = 0; i < 8; i++) push(1'b1, hdr[i], 1'b0, "R1");
    for (int i = 0; i < t; i++) push(1'b0, 1'b0, 1'b1, "R3");
    for (int i = 0; i < 3; i++) push(1'b0, 1'b0, ack[i], "R4");
    ok = (ack == 3'b001);
    if (ok && rd) begin
      for (int i = 0; i < 32; i++) push(1'b0, 1'b0, rdv[i], "R5");
      push(1'b0, 1'b0, (^rdv) ^ bad_par, "R5");
      for (int i = 0; i < t; i++) push(1'b0, 1'b0, 1'b0, "R3");
    end else if (ok) begin
      for (int i = 0; i < t; i++) push(1'b0, 1'b0, 1'b1, "R3");
      for (int i = 0; i < 32; i++) push(1'b1, wd[i], 1'b0, "R6");
      push(1'b1, ^wd, 1'b0, "R6");
    end else begin
      for (int i = 0; i < t; i++) push(1'b0, 1'b0, 1'b1, "R7");
    end
    x_rdata = (ok && rd) ? rdv : 32'h0;
    x_perr  = ok && rd && bad_par;
    x_proto = !(ack == 3'b001 || ack == 3'b010 || ack == 3'b100);

    @(negedge clk);
    req_ap = ap; req_read = rd; req_addr = addr; req_wdata = wd; trn_len = trn;
    req_valid = 1'b1;
    chk(32'(req_ready), 32'd1, "R9", "ready when idle");
    @(negedge clk);
    req_valid = 1'b0; req_wdata = 32'h0; trn_len = 2'd3;
    for (int b = 0; b < nb; b++) begin
      for (int c = 0; c < 2 * H; c++) begin
        swdio_in = e_in[b];
        chk(32'(swclk), 32'(c >= H), "R2", $sformatf("swclk bit %0d", b));
        chk(32'(swdio_oe), 32'(e_oe[b]), e_tag[b], $sformatf("oe bit %0d", b));
        chk(32'(swdio_out), 32'(e_out[b]), e_tag[b], $sformatf("out bit %0d", b));
        chk({busy, req_ready, done}, 32'b100, "R9", "busy/ready/done during access");
        @(negedge clk);
      end
    end
    swdio_in = 1'b0;
    chk({busy, done}, 32'b01, "R9", "done pulse at end");
    chk(32'(rsp_ack), 32'(ack), "R4", "ack code");
    chk(rsp_rdata, x_rdata, ok ? "R5" : "R7", "read word");
    chk(32'(rsp_perr), 32'(x_perr), ok ? "R5" : "R7", "parity flag");
    chk(32'(rsp_proto_err), 32'(x_proto), "R8", "protocol flag");
    chk({swclk, swdio_oe, swdio_out}, 32'b000, "R10", "pin released at end");
    @(negedge clk);
    chk({busy, done, req_ready}, 32'b001, "R9", "done is one cycle");
    chk({rsp_ack, rsp_perr, rsp_proto_err}, {ack, x_perr, x_proto}, "R9", "results held");
    chk(rsp_rdata, x_rdata, "R9", "read word held");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, req_ready}, 32'b001, "R9", "reset handshake");
    chk({swclk, swdio_oe, swdio_out}, 32'b000, "R10", "reset pin state");
    chk(32'(rsp_ack), 32'd0, "R4", "reset ack");
    run_txn(1'b0, 1'b1, 2'd0, 32'h0,        3'b001, 32'h12345678, 1'b0, 2'd1);
    run_txn(1'b1, 1'b1, 2'd2, 32'h0,        3'b001, 32'hA5A5F00F, 1'b1, 2'd2);
    run_txn(1'b1, 1'b0, 2'd3, 32'hDEADBEEF, 3'b001, 32'h0,        1'b0, 2'd3);
    run_txn(1'b0, 1'b0, 2'd1, 32'h0F0F0001, 3'b010, 32'h0,        1'b0, 2'd0);
    run_txn(1'b1, 1'b1, 2'd1, 32'h0,        3'b100, 32'hFFFF0000, 1'b0, 2'd1);
    run_txn(1'b0, 1'b1, 2'd3, 32'h0,        3'b111, 32'h0,        1'b0, 2'd1);
    run_txn(1'b1, 1'b0, 2'd0, 32'h11111111, 3'b000, 32'h0,        1'b0, 2'd2);
    run_txn(1'b0, 1'b0, 2'd2, 32'h00000000, 3'b001, 32'h0,        1'b0, 2'd0);
    run_txn(1'b0, 1'b0, 2'd1, 32'hFFFFFFFF, 3'b001, 32'h0,        1'b0, 2'd1);
    run_txn(1'b1, 1'b1, 2'd3, 32'h0,        3'b001, 32'h00000001, 1'b0, 2'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule